// File: doc/BRIEF.md
# Register-to-register move unit

This block executes the 8-bit move group of a small 8-bit processor. An opcode byte arrives with a valid strobe. When the opcode's two top bits are 01 (and it is not the halt code), three low bits pick a source and three middle bits pick a destination out of eight slots: six byte registers, one slot that stands for memory addressed by the H:L pair, and the accumulator. The unit copies the byte, drives a synchronous memory port when the memory slot is involved, and reports how many machine cycles the move took.

The pattern that would copy memory to memory is the halt code instead. Taking it latches a halted state that blocks all further opcodes until reset. The unit also holds the register file itself, a load and a peek port for that file, and a free-running count of machine cycles consumed. One clock equals one machine cycle.

Top module: `regmove_core`

## Requirements
- R1: An opcode executes only when bits 7:6 equal 01 and it is not 0x76. Any other opcode is dropped: no done pulse, no memory access, no register change and no cycle count.
- R2: Opcode 0x76 raises `halted` and gives a done pulse with `mcycles`=1. After that, `op_ready` stays low and opcodes have no effect until reset.
- R3: Opcode bits 2:0 choose the source slot: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory at H:L, 7=A.
- R4: Opcode bits 5:3 choose the destination slot, using the same numbering as R3.
- R5: A move between two registers writes the destination at the acceptance edge. `done` is high in the following cycle, with `mcycles`=1.
- R6: When the source is slot 6, `mem_rd` is high during the acceptance cycle, with `mem_addr`={H,L}, H in the high byte. The data returned one cycle later lands in the destination, and `done` then shows `mcycles`=2.
- R7: When the destination is slot 6, `mem_wr` is high in the cycle after acceptance, with `mem_addr`={H,L} and `mem_wdata` equal to the source register. `done` then shows `mcycles`=2.
- R8: `op_ready` is low during the second cycle of a memory move.
- R9: `cycle_count` adds the machine cycles of every executed move or halt and wraps modulo 2^CNT_W.
- R10: The load port writes a register when `ld_en` is high. A load to index 6 changes nothing. A move that writes the same slot in the same cycle takes precedence over the load.
- R11: After reset, all registers are 0, `halted`, `done` and `cycle_count` are 0, and `op_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| op_valid | input | 1 | Opcode strobe |
| opcode | input | 8 | Opcode byte |
| op_ready | output | 1 | The unit accepts an opcode in this cycle |
| done | output | 1 | One-cycle pulse when a move or halt finishes |
| mcycles | output | 2 | Machine cycles used by the last finished operation |
| halted | output | 1 | Halt latched |
| cycle_count | output | CNT_W | Running total of machine cycles |
| mem_addr | output | 2*DATA_W | Memory address {H,L} |
| mem_rd | output | 1 | Memory read request; data is due on the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| ld_en | input | 1 | Register load enable |
| ld_idx | input | 3 | Register load index |
| ld_data | input | DATA_W | Register load value |
| peek_idx | input | 3 | Register observe index |
| peek_data | output | DATA_W | Register observe value; reads 0 for index 6 |

## Verification
The bench builds the unit with DATA_W=8 and CNT_W=4. The narrow counter wraps after sixteen machine cycles, so a single sweep over all register pairs carries it through several wraps, and the modulo rule is checked alongside the per-move cycle cost. The 8-bit data width keeps the H:L address at sixteen bits, so distinct H and L values show which byte sits high.

// File: rtl/regmove_pkg.sv
package regmove_pkg;
  localparam int IDX_W = 3;
  localparam int NSLOT = 1 << IDX_W;
  localparam logic [IDX_W-1:0] SLOT_MEM = 3'd6;
  localparam logic [IDX_W-1:0] SLOT_H   = 3'd4;
  localparam logic [IDX_W-1:0] SLOT_L   = 3'd5;
  localparam logic [7:0]       OP_HALT  = 8'h76;
  localparam logic [1:0]       GROUP_TAG = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MRD  = 2'd1,
    ST_MWR  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic             in_group;
    logic             is_halt;
    logic [IDX_W-1:0] src;
    logic [IDX_W-1:0] dst;
    logic             src_mem;
    logic             dst_mem;
  } dec_t;
endpackage

// File: rtl/regmove_decode.sv
module regmove_decode
  import regmove_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);
  logic tag_hit;

  always_comb begin
    tag_hit      = (opcode[7:6] == GROUP_TAG);
    dec.is_halt  = (opcode == OP_HALT);
    dec.in_group = tag_hit && !dec.is_halt;
    dec.src      = opcode[2:0];
    dec.dst      = opcode[5:3];
    dec.src_mem  = (opcode[2:0] == SLOT_MEM);
    dec.dst_mem  = (opcode[5:3] == SLOT_MEM);
  end

  always_comb begin
    AST_HALT_OUTSIDE: assert (!(dec.in_group && dec.src_mem && dec.dst_mem)); // R2
  end
endmodule

// File: rtl/regmove_regfile.sv
module regmove_regfile
  import regmove_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ex_we,
  input  logic [IDX_W-1:0]    ex_idx,
  input  logic [DATA_W-1:0]   ex_data,
  input  logic                ld_en,
  input  logic [IDX_W-1:0]    ld_idx,
  input  logic [DATA_W-1:0]   ld_data,
  input  logic [IDX_W-1:0]    src_idx,
  output logic [DATA_W-1:0]   src_data,
  input  logic [IDX_W-1:0]    peek_idx,
  output logic [DATA_W-1:0]   peek_data,
  output logic [2*DATA_W-1:0] hl_addr
);
  logic [NSLOT-1:0][DATA_W-1:0] slot_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g == int'(SLOT_MEM)) begin : g_hole
      assign slot_q[g] = '0;
    end else begin : g_reg
      logic              hit_ex;
      logic              hit_ld;
      logic              we;
      logic [DATA_W-1:0] d;
      logic [DATA_W-1:0] q;

      always_comb begin
        hit_ex = ex_we && (ex_idx == IDX_W'(g));
        hit_ld = ld_en && (ld_idx == IDX_W'(g));
        we     = hit_ex || hit_ld;
        d      = hit_ex ? ex_data : ld_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (we) begin
          q <= d;
        end
      end

      assign slot_q[g] = q;
    end
  end

  assign src_data  = slot_q[src_idx];
  assign peek_data = slot_q[peek_idx];
  assign hl_addr   = {slot_q[SLOT_H], slot_q[SLOT_L]};
endmodule

// File: rtl/regmove_seq.sv
module regmove_seq
  import regmove_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  dec_t             dec,
  output logic             ready,
  output logic             ex_we,
  output logic             ex_from_mem,
  output logic [IDX_W-1:0] ex_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             done,
  output logic [1:0]       used_mc,
  output logic             halted,
  output logic [CNT_W-1:0] cyc_cnt
);
  seq_state_e       state_q, state_d;
  logic             halted_q, halted_d;
  logic             done_q, done_d;
  logic [1:0]       used_q, used_d;
  logic             used_en;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;
  logic [IDX_W-1:0] lat_src_q, lat_dst_q;
  logic             lat_en;
  logic             accept, go, halt_go;

  always_comb begin
    ready   = (state_q == ST_IDLE) && !halted_q;
    accept  = ready && op_valid;
    go      = accept && dec.in_group;
    halt_go = accept && dec.is_halt;
  end

  // next-state
  always_comb begin
    state_d     = state_q;
    halted_d    = halted_q;
    done_d      = 1'b0;
    used_d      = used_q;
    used_en     = 1'b0;
    cnt_en      = 1'b0;
    lat_en      = 1'b0;
    ex_we       = 1'b0;
    ex_from_mem = 1'b0;
    ex_idx      = dec.dst;
    rd_idx      = dec.src;
    mem_rd      = 1'b0;
    mem_wr      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          lat_en = 1'b1;
          cnt_en = 1'b1;
          if (dec.src_mem) begin
            mem_rd  = 1'b1;
            state_d = ST_MRD;
          end else if (dec.dst_mem) begin
            state_d = ST_MWR;
          end else begin
            ex_we   = 1'b1;
            done_d  = 1'b1;
            used_d  = 2'd1;
            used_en = 1'b1;
          end
        end else if (halt_go) begin
          halted_d = 1'b1;
          done_d   = 1'b1;
          used_d   = 2'd1;
          used_en  = 1'b1;
          cnt_en   = 1'b1;
        end
      end
      ST_MRD: begin
        ex_we       = 1'b1;
        ex_from_mem = 1'b1;
        ex_idx      = lat_dst_q;
        done_d      = 1'b1;
        used_d      = 2'd2;
        used_en     = 1'b1;
        cnt_en      = 1'b1;
        state_d     = ST_IDLE;
      end
      ST_MWR: begin
        rd_idx  = lat_src_q;
        mem_wr  = 1'b1;
        done_d  = 1'b1;
        used_d  = 2'd2;
        used_en = 1'b1;
        cnt_en  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      halted_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      halted_q <= halted_d;
      done_q   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= 2'd0;
    end else if (used_en) begin
      used_q <= used_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_src_q <= '0;
      lat_dst_q <= '0;
    end else if (lat_en) begin
      lat_src_q <= dec.src;
      lat_dst_q <= dec.dst;
    end
  end

  assign done    = done_q;
  assign used_mc = used_q;
  assign halted  = halted_q;
  assign cyc_cnt = cnt_q;

  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R6
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> halted_q); // R2
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |-> (!mem_rd && !mem_wr && !ex_we)); // R2
  AST_RD_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (ex_we && ex_from_mem)); // R6
  AST_WR_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (state_q == ST_IDLE)); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !ready); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)))); // R9
  AST_DONE_COST: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (used_q == 2'd1 || used_q == 2'd2)); // R5
endmodule

// File: rtl/regmove_core.sv
module regmove_core
  import regmove_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [7:0]          opcode,
  output logic                op_ready,
  output logic                done,
  output logic [1:0]          mcycles,
  output logic                halted,
  output logic [CNT_W-1:0]    cycle_count,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                ld_en,
  input  logic [2:0]          ld_idx,
  input  logic [DATA_W-1:0]   ld_data,
  input  logic [2:0]          peek_idx,
  output logic [DATA_W-1:0]   peek_data
);
  logic [1:0]        rst_pipe;
  logic              rst_n_int;
  dec_t              dec;
  logic              ex_we, ex_from_mem;
  logic [IDX_W-1:0]  ex_idx, rd_idx;
  logic [DATA_W-1:0] src_data, ex_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe[1];

  regmove_decode i_dec (
    .opcode (opcode),
    .dec    (dec)
  );

  regmove_seq #(.CNT_W(CNT_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .op_valid    (op_valid),
    .dec         (dec),
    .ready       (op_ready),
    .ex_we       (ex_we),
    .ex_from_mem (ex_from_mem),
    .ex_idx      (ex_idx),
    .rd_idx      (rd_idx),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .done        (done),
    .used_mc     (mcycles),
    .halted      (halted),
    .cyc_cnt     (cycle_count)
  );

  assign ex_data = ex_from_mem ? mem_rdata : src_data;

  regmove_regfile #(.DATA_W(DATA_W)) i_rf (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .ex_we     (ex_we),
    .ex_idx    (ex_idx),
    .ex_data   (ex_data),
    .ld_en     (ld_en),
    .ld_idx    (ld_idx),
    .ld_data   (ld_data),
    .src_idx   (rd_idx),
    .src_data  (src_data),
    .peek_idx  (peek_idx),
    .peek_data (peek_data),
    .hl_addr   (mem_addr)
  );

  assign mem_wdata = src_data;

  AST_WR_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    mem_wr |-> $stable(mem_addr)); // R7
endmodule

// File: tb/test_regmove_core.sv
module test_regmove_core;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [7:0]    opcode = 8'h00;
  logic          op_ready, done, halted;
  logic [1:0]    mcycles;
  logic [CW-1:0] cycle_count;
  logic [15:0]   mem_addr;
  logic          mem_rd, mem_wr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata = 8'h00;
  logic          ld_en = 1'b0;
  logic [2:0]    ld_idx = 3'd0;
  logic [7:0]    ld_data = 8'h00;
  logic [2:0]    peek_idx = 3'd0;
  logic [7:0]    peek_data;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  int rd_seen = 0;
  int wr_seen = 0;
  logic [15:0] rd_addr_seen, wr_addr_seen;
  logic [7:0]  wr_data_seen;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regmove_core #(.DATA_W(DW), .CNT_W(CW)) i_regmove_core (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .op_ready(op_ready), .done(done), .mcycles(mcycles), .halted(halted),
    .cycle_count(cycle_count), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .peek_idx(peek_idx), .peek_data(peek_data)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // memory model: synchronous read, data due the cycle after the request
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata    <= mem_byte(mem_addr);
      rd_addr_seen <= mem_addr;
      rd_seen      <= rd_seen + 1;
    end
    if (mem_wr) begin
      wr_addr_seen <= mem_addr;
      wr_data_seen <= mem_wdata;
      wr_seen      <= wr_seen + 1;
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op_valid = 1'b0;
    ld_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_cnt = 0;
  endtask

  task automatic load(input int idx, input logic [7:0] val);
    @(negedge clk);
    ld_en = 1'b1;
    ld_idx = 3'(idx);
    ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic peek(input int idx, output logic [7:0] val);
    peek_idx = 3'(idx);
    #1;
    val = peek_data;
  endtask

  // issue one opcode; lat = negedges after the accept edge until done (0: none)
  task automatic run_op(input logic [7:0] op, output int lat, output logic [1:0] used,
                        output logic rdy_mid);
    @(negedge clk);
    op_valid = 1'b1;
    opcode = op;
    @(negedge clk);
    op_valid = 1'b0;
    lat = 0;
    used = 2'd0;
    rdy_mid = op_ready;
    for (int k = 1; k <= 3; k++) begin
      if (done && lat == 0) begin
        lat = k;
        used = mcycles;
      end
      if (k < 3) @(negedge clk);
    end
  endtask

  function automatic logic [7:0] seed(input int i);
    return 8'((i * 8'h23) + 8'h11);
  endfunction

  task automatic load_all();
    for (int i = 0; i < 8; i++) begin
      if (i != 6) load(i, seed(i));
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R11 halted", halted == 1'b0, halted, 0);
    chk("R11 done", done == 1'b0, done, 0);
    chk("R11 ready", op_ready == 1'b1, op_ready, 1);
    chk("R11 count", cycle_count == 0, cycle_count, 0);
    for (int i = 0; i < 8; i++) begin
      peek(i, v);
      chk("R11 register", v == 8'h00, v, 0);
    end
  endtask

  task automatic t_reg_pairs();
    int lat;
    logic [1:0] used;
    logic rdy;
    logic [7:0] v;
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 8; d++) begin
        if (s != 6 && d != 6) begin
          load_all();
          run_op({2'b01, 3'(d), 3'(s)}, lat, used, rdy);
          exp_cnt += 1;
          peek(d, v);
          chk("R3 R4 dest gets source", v == seed(s), v, seed(s));
          chk("R5 latency", lat == 1, lat, 1);
          chk("R5 mcycles", used == 2'd1, used, 1);
          for (int o = 0; o < 8; o++) begin
            if (o != 6 && o != d) begin
              peek(o, v);
              chk("R4 other slot untouched", v == seed(o), v, seed(o));
            end
          end
        end
      end
    end
    chk("R9 count after wraps", int'(cycle_count) == (exp_cnt % 16), cycle_count, exp_cnt % 16);
  endtask

  task automatic t_mem_read();
    int lat;
    logic [1:0] used;
    logic rdy;
    logic [7:0] v;
    int rd0;
    load(4, 8'h12);
    load(5, 8'h34);
    rd0 = rd_seen;
    run_op(8'h7E, lat, used, rdy);
    exp_cnt += 2;
    peek(7, v);
    chk("R6 read address H:L", rd_addr_seen == 16'h1234, rd_addr_seen, 16'h1234);
    chk("R6 one read", rd_seen == rd0 + 1, rd_seen, rd0 + 1);
    chk("R6 dest gets memory", v == mem_byte(16'h1234), v, mem_byte(16'h1234));
    chk("R6 latency", lat == 2, lat, 2);
    chk("R6 mcycles", used == 2'd2, used, 2);
    chk("R8 not ready mid-move", rdy == 1'b0, rdy, 0);
    // load H from memory: address uses old H
    run_op(8'h66, lat, used, rdy);
    exp_cnt += 2;
    peek(4, v);
    chk("R6 H from memory", v == mem_byte(16'h1234), v, mem_byte(16'h1234));
    chk("R9 count", int'(cycle_count) == (exp_cnt % 16), cycle_count, exp_cnt % 16);
  endtask

  task automatic t_mem_write();
    int lat;
    logic [1:0] used;
    logic rdy;
    int wr0;
    load(4, 8'hA0);
    load(5, 8'h0B);
    load(3, 8'hE7);
    wr0 = wr_seen;
    run_op(8'h73, lat, used, rdy);
    exp_cnt += 2;
    chk("R7 write address H:L", wr_addr_seen == 16'hA00B, wr_addr_seen, 16'hA00B);
    chk("R7 write data", wr_data_seen == 8'hE7, wr_data_seen, 8'hE7);
    chk("R7 one write", wr_seen == wr0 + 1, wr_seen, wr0 + 1);
    chk("R7 latency", lat == 2, lat, 2);
    chk("R7 mcycles", used == 2'd2, used, 2);
    chk("R8 not ready mid-move", rdy == 1'b0, rdy, 0);
    run_op(8'h74, lat, used, rdy);
    exp_cnt += 2;
    chk("R7 write H", wr_data_seen == 8'hA0, wr_data_seen, 8'hA0);
    chk("R9 count", int'(cycle_count) == (exp_cnt % 16), cycle_count, exp_cnt % 16);
  endtask

  task automatic t_ignored();
    int lat;
    logic [1:0] used;
    logic rdy;
    logic [7:0] v;
    logic [7:0] ops [4] = '{8'h00, 8'h3E, 8'h80, 8'hC3};
    int r0, w0;
    load_all();
    for (int i = 0; i < 4; i++) begin
      r0 = rd_seen;
      w0 = wr_seen;
      run_op(ops[i], lat, used, rdy);
      chk("R1 no done", lat == 0, lat, 0);
      chk("R1 no memory access", rd_seen == r0 && wr_seen == w0, rd_seen + wr_seen, r0 + w0);
      for (int o = 0; o < 8; o++) begin
        if (o != 6) begin
          peek(o, v);
          chk("R1 registers unchanged", v == seed(o), v, seed(o));
        end
      end
    end
    chk("R1 count unchanged", int'(cycle_count) == (exp_cnt % 16), cycle_count, exp_cnt % 16);
  endtask

  task automatic t_load_rules();
    logic [7:0] v;
    int w0;
    load_all();
    w0 = wr_seen;
    load(6, 8'h99);
    chk("R10 index 6 no memory write", wr_seen == w0, wr_seen, w0);
    for (int o = 0; o < 8; o++) begin
      peek(o, v);
      chk("R10 index 6 ignored", v == ((o == 6) ? 8'h00 : seed(o)), v, (o == 6) ? 0 : seed(o));
    end
    // same-cycle move and load on B: move wins
    @(negedge clk);
    op_valid = 1'b1;
    opcode = 8'h41;
    ld_en = 1'b1;
    ld_idx = 3'd0;
    ld_data = 8'h5D;
    @(negedge clk);
    op_valid = 1'b0;
    ld_en = 1'b0;
    exp_cnt += 1;
    peek(0, v);
    chk("R10 move beats load", v == seed(1), v, seed(1));
  endtask

  task automatic t_halt();
    int lat;
    logic [1:0] used;
    logic rdy;
    logic [7:0] v;
    load_all();
    run_op(8'h76, lat, used, rdy);
    exp_cnt += 1;
    chk("R2 halt done", lat == 1, lat, 1);
    chk("R2 halt mcycles", used == 2'd1, used, 1);
    chk("R2 halted", halted == 1'b1, halted, 1);
    chk("R2 not ready", op_ready == 1'b0, op_ready, 0);
    run_op(8'h41, lat, used, rdy);
    peek(0, v);
    chk("R2 move ignored", v == seed(0), v, seed(0));
    chk("R2 no done", lat == 0, lat, 0);
    chk("R2 count frozen", int'(cycle_count) == (exp_cnt % 16), cycle_count, exp_cnt % 16);
    do_reset();
    chk("R11 halt cleared", halted == 1'b0, halted, 0);
    chk("R11 ready again", op_ready == 1'b1, op_ready, 1);
    chk("R11 count cleared", cycle_count == 0, cycle_count, 0);
    peek(0, v);
    chk("R11 register cleared", v == 8'h00, v, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_reg_pairs();
    t_mem_read();
    t_mem_write();
    t_ignored();
    t_load_rules();
    t_halt();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule